// File: doc/BRIEF.md
# Transceiver Configuration Request Sequencer

This block sits in the fabric between user logic and the configuration ports of a group of serial transceiver channels. User logic issues single-cycle request pulses. A pulse can write one configuration word, read one word back, or write a whole configuration image. The sequencer turns each accepted pulse into one or more handshaked transactions on a simple register port. The channel is chosen by a logical channel address. The block reports its progress through a busy flag, a read-data-valid strobe and an error strobe.

When reset is released, the block first calibrates every attached receiver channel in turn. For each channel it issues one start strobe and waits for that channel's done acknowledge. No user request is accepted until the sweep is over. An image write reads its words from an external word source, which returns data a fixed number of clock cycles after it is addressed. Word i of the image goes to register i of the selected channel. Requests that cannot be served produce a two-cycle error strobe, and no transaction follows.

Top module: `xcvr_cfg_sequencer`

## Requirements
- R1: While reset is held and for the first cycle after its release, busy is low. Busy then rises and stays high for the whole calibration sweep. The sweep issues one single-cycle `cal_start` per channel, with `cal_ch` taking the values 0, 1, ... NUM_CH-1 in that order. Each next start waits for `cal_done`. Busy falls only after `cal_done` has been seen for the last channel.
- R2: A `req_wr` pulse with a legal channel performs exactly one target transaction with `tgt_we`=1. The transaction carries the sampled `ch_addr`, `reg_addr` and `wr_data`.
- R3: A `req_rd` pulse performs exactly one target transaction with `tgt_we`=0. In the cycle after `tgt_ack`, `rd_valid` is high for exactly one cycle and `rd_data` holds the `tgt_rdata` that came with the acknowledge.
- R4: A single `req_img` pulse writes IMG_LEN words to register addresses 0 to IMG_LEN-1 of the selected channel. Word i is the `img_word` value the source returns for `img_addr`=i. The source answers with a latency of SRC_LAT cycles, and `img_addr` is held steady until the word is consumed. The next word is fetched only after the previous one has been acknowledged.
- R5: Busy is high from the cycle after an accepted request up to and including the cycle that carries the final `tgt_ack`. It is low in the cycle after that.
- R6: Once `tgt_req` rises, it stays high with `tgt_we`, `tgt_ch`, `tgt_addr` and `tgt_wdata` unchanged until `tgt_ack` is seen. It drops in the cycle after the acknowledge.
- R7: A request is unsupported if `ch_addr` >= NUM_CH, if two or more request pulses arrive in the same cycle, or if it is a read while READ_EN=0. Such a request raises `error` for exactly two cycles starting the cycle after the pulse. Busy stays low during that time and no target transaction takes place.
- R8: Request pulses that arrive while busy or error is high are dropped. They cause no later transaction and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_wr | input | 1 | One-cycle pulse: write one word |
| req_rd | input | 1 | One-cycle pulse: read one word |
| req_img | input | 1 | One-cycle pulse: write the whole image |
| ch_addr | input | CH_W | Logical channel address. Width is 1 for up to 2 channels, 2 for 3-4, 3 for 5-8, 4 for 9-16. A single-channel build ties it to 0. |
| reg_addr | input | RA_W | Register address for single-word requests |
| wr_data | input | DATA_W | Data for a single-word write |
| busy | output | 1 | Sweep or transaction in progress |
| rd_valid | output | 1 | One-cycle strobe: rd_data is valid |
| rd_data | output | DATA_W | Last word read back |
| error | output | 1 | Two-cycle strobe for an unsupported request |
| img_addr | output | IMG_W | Index of the image word being fetched |
| img_word | input | DATA_W | Image word, SRC_LAT cycles after img_addr |
| cal_start | output | 1 | Starts calibration of cal_ch |
| cal_ch | output | CH_W | Channel being calibrated |
| cal_done | input | 1 | Calibration of cal_ch finished |
| tgt_req | output | 1 | Target transaction request |
| tgt_we | output | 1 | 1 = write, 0 = read |
| tgt_ch | output | CH_W | Target channel |
| tgt_addr | output | RA_W | Target register address |
| tgt_wdata | output | DATA_W | Target write data |
| tgt_ack | input | 1 | One-cycle acknowledge from target |
| tgt_rdata | input | DATA_W | Read data, valid with tgt_ack |

## Verification
The bench counts busy cycles exactly, for a single word and for the whole image. A design that sampled the word source one cycle early, or let busy fall between image words, would show a different count or wrong words in the target memory. The calibration log is compared against the ascending channel order, and busy must fall only after all channels have been done. A sequencer that skipped a channel or released busy mid-sweep would leave the log short. Out-of-range channels and simultaneous pulses are driven to check the two-cycle error strobe with busy low. Pulses issued during a transfer or during the error strobe must leave the target untouched; a design that queued or accepted them would produce an extra transaction.

// File: rtl/xcvr_cfg_sequencer.sv
module xcvr_cfg_sequencer #(
  parameter int NUM_CH  = 3,
  parameter int DATA_W  = 16,
  parameter int RA_W    = 4,
  parameter int IMG_LEN = 6,
  parameter int SRC_LAT = 2,
  parameter bit READ_EN = 1'b1,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int IMG_W = (IMG_LEN > 1) ? $clog2(IMG_LEN) : 1,
  localparam int LAT_W = $clog2(SRC_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_wr,
  input  logic              req_rd,
  input  logic              req_img,
  input  logic [CH_W-1:0]   ch_addr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              error,
  output logic [IMG_W-1:0]  img_addr,
  input  logic [DATA_W-1:0] img_word,
  output logic              cal_start,
  output logic [CH_W-1:0]   cal_ch,
  input  logic              cal_done,
  output logic              tgt_req,
  output logic              tgt_we,
  output logic [CH_W-1:0]   tgt_ch,
  output logic [RA_W-1:0]   tgt_addr,
  output logic [DATA_W-1:0] tgt_wdata,
  input  logic              tgt_ack,
  input  logic [DATA_W-1:0] tgt_rdata
);

  localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(NUM_CH - 1);
  localparam logic [CH_W:0]    CH_LIM   = (CH_W + 1)'(NUM_CH);
  localparam logic [IMG_W-1:0] IMG_LAST = IMG_W'(IMG_LEN - 1);
  localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(SRC_LAT);

  typedef enum logic [2:0] {
    S_BOOT, S_CAL_GO, S_CAL_WAIT, S_IDLE, S_XFER, S_FETCH, S_ERR
  } state_t;

  state_t           st;
  logic             img_mode;
  logic             err_2nd;
  logic [IMG_W-1:0] idx;
  logic [LAT_W-1:0] lat_cnt;
  logic [1:0]       nreq;
  logic             bad;

  assign nreq      = 2'($countones({req_wr, req_rd, req_img}));
  assign bad       = (nreq > 2'd1) || ({1'b0, ch_addr} >= CH_LIM) || (req_rd && !READ_EN);
  assign busy      = !(st inside {S_BOOT, S_IDLE, S_ERR});
  assign error     = (st == S_ERR);
  assign cal_start = (st == S_CAL_GO);
  assign tgt_req   = (st == S_XFER);
  assign img_addr  = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_BOOT;
      cal_ch    <= '0;
      img_mode  <= 1'b0;
      err_2nd   <= 1'b0;
      idx       <= '0;
      lat_cnt   <= '0;
      tgt_we    <= 1'b0;
      tgt_ch    <= '0;
      tgt_addr  <= '0;
      tgt_wdata <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_BOOT:   st <= S_CAL_GO;
        S_CAL_GO: st <= S_CAL_WAIT;
        S_CAL_WAIT:
          if (cal_done) begin
            if (cal_ch == CH_LAST) st <= S_IDLE;
            else begin
              cal_ch <= cal_ch + 1'b1;
              st     <= S_CAL_GO;
            end
          end
        S_IDLE:
          if (nreq != 2'd0) begin
            if (bad) begin
              err_2nd <= 1'b0;
              st      <= S_ERR;
            end else begin
              tgt_ch   <= ch_addr;
              img_mode <= req_img;
              if (req_img) begin
                idx     <= '0;
                lat_cnt <= '0;
                tgt_we  <= 1'b1;
                st      <= S_FETCH;
              end else begin
                tgt_we    <= req_wr;
                tgt_addr  <= reg_addr;
                tgt_wdata <= wr_data;
                st        <= S_XFER;
              end
            end
          end
        S_FETCH:
          if (lat_cnt == LAT_LAST) begin
            tgt_wdata <= img_word;
            tgt_addr  <= RA_W'(idx);
            st        <= S_XFER;
          end else begin
            lat_cnt <= lat_cnt + 1'b1;
          end
        S_XFER:
          if (tgt_ack) begin
            if (!img_mode) begin
              if (!tgt_we) begin
                rd_valid <= 1'b1;
                rd_data  <= tgt_rdata;
              end
              st <= S_IDLE;
            end else if (idx == IMG_LAST) begin
              st <= S_IDLE;
            end else begin
              idx     <= idx + 1'b1;
              lat_cnt <= '0;
              st      <= S_FETCH;
            end
          end
        S_ERR:
          if (err_2nd) st <= S_IDLE;
          else err_2nd <= 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_cal_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> busy && !tgt_req);

  p_rdv_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(tgt_ack) && !$past(tgt_we));

  p_rdv_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_req_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req |-> busy);

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req && !tgt_ack |=> tgt_req && $stable(tgt_we) && $stable(tgt_ch)
                            && $stable(tgt_addr) && $stable(tgt_wdata));

  p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req && tgt_ack |=> !tgt_req || busy);

  p_err_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |=> error);

  p_err_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    error && $past(error) |=> !error);

  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !busy && !tgt_req);

  p_drop_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (req_wr || req_rd || req_img) |=> !error);

endmodule

// File: tb/tb_xcvr_cfg_sequencer.sv
module tb_xcvr_cfg_sequencer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_wr = 1'b0, req_rd = 1'b0, req_img = 1'b0;
  logic [1:0]  ch_addr = '0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy, rd_valid, error;
  logic [15:0] rd_data;
  logic [2:0]  img_addr;
  logic [15:0] img_word;
  logic        cal_start, cal_done;
  logic [1:0]  cal_ch;
  logic        tgt_req, tgt_we, tgt_ack;
  logic [1:0]  tgt_ch;
  logic [3:0]  tgt_addr;
  logic [15:0] tgt_wdata, tgt_rdata;

  int n_chk = 0, n_bad = 0;
  int txn, wcnt, cal_n, cal_wait, hold_viol;
  int cal_log [0:7];
  logic [15:0] tmem [0:3][0:15];
  logic [15:0] src_p0, src_p1;

  always #4 clk = ~clk;

  xcvr_cfg_sequencer dut (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_rd(req_rd), .req_img(req_img),
    .ch_addr(ch_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .error(error),
    .img_addr(img_addr), .img_word(img_word),
    .cal_start(cal_start), .cal_ch(cal_ch), .cal_done(cal_done),
    .tgt_req(tgt_req), .tgt_we(tgt_we), .tgt_ch(tgt_ch), .tgt_addr(tgt_addr),
    .tgt_wdata(tgt_wdata), .tgt_ack(tgt_ack), .tgt_rdata(tgt_rdata)
  );

  function automatic logic [15:0] src_fn(input logic [2:0] i);
    return 16'hC300 ^ ({13'd0, i} * 16'h0123) ^ {8'd0, 5'd0, i};
  endfunction

  always @(posedge clk) begin
    src_p0 <= src_fn(img_addr);
    src_p1 <= src_p0;
  end
  assign img_word = src_p1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_ack <= 1'b0; wcnt <= 0; tgt_rdata <= '0; txn <= 0;
      for (int c = 0; c < 4; c++)
        for (int a = 0; a < 16; a++) tmem[c][a] <= 16'h0;
    end else begin
      tgt_ack <= 1'b0;
      if (tgt_req && !tgt_ack) begin
        if (wcnt == 2) begin
          tgt_ack <= 1'b1; wcnt <= 0; txn <= txn + 1;
          if (tgt_we) tmem[tgt_ch][tgt_addr] <= tgt_wdata;
          else tgt_rdata <= tmem[tgt_ch][tgt_addr];
        end else wcnt <= wcnt + 1;
      end
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_done <= 1'b0; cal_n <= 0; cal_wait <= 0;
    end else begin
      cal_done <= 1'b0;
      if (cal_start) begin
        if (cal_n < 8) cal_log[cal_n] <= int'(cal_ch);
        cal_n <= cal_n + 1; cal_wait <= 3;
      end else if (cal_wait != 0) begin
        cal_wait <= cal_wait - 1;
        if (cal_wait == 1) cal_done <= 1'b1;
      end
    end
  end

  logic        p_req, p_ack, p_we;
  logic [1:0]  p_ch;
  logic [3:0]  p_addr;
  logic [15:0] p_wd;
  initial hold_viol = 0;
  always @(negedge clk) begin
    if (rst_n && p_req && !p_ack &&
        (!tgt_req || tgt_we != p_we || tgt_ch != p_ch || tgt_addr != p_addr || tgt_wdata != p_wd))
      hold_viol <= hold_viol + 1;
    p_req <= tgt_req; p_ack <= tgt_ack; p_we <= tgt_we;
    p_ch <= tgt_ch; p_addr <= tgt_addr; p_wd <= tgt_wdata;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic fire(input logic w, input logic r, input logic im,
                      input logic [1:0] ch, input logic [3:0] ra, input logic [15:0] d);
    @(negedge clk);
    req_wr = w; req_rd = r; req_img = im; ch_addr = ch; reg_addr = ra; wr_data = d;
    @(negedge clk);
    req_wr = 1'b0; req_rd = 1'b0; req_img = 1'b0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_cal();
    int n;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 busy low first cycle", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R1 busy high in sweep", {31'd0, busy}, 32'd1);
    count_busy(n);
    chk("R1 channels calibrated", cal_n, 32'd3);
    for (int k = 0; k < 3; k++) chk("R1 calibration order", cal_log[k], k);
  endtask

  task automatic t_write_word();
    int n, t0;
    t0 = txn;
    fire(1'b1, 1'b0, 1'b0, 2'd1, 4'd5, 16'h1234);
    count_busy(n);
    chk("R5 busy cycles word write", n, 32'd4);
    chk("R2 written word", {16'd0, tmem[1][5]}, 32'h1234);
    chk("R2 one transaction", txn - t0, 32'd1);
  endtask

  task automatic t_read_word();
    int n;
    fire(1'b0, 1'b1, 1'b0, 2'd1, 4'd5, 16'h0);
    n = 0;
    while (!rd_valid && n < 50) begin n++; @(negedge clk); end
    chk("R3 rd_valid seen", {31'd0, rd_valid}, 32'd1);
    chk("R3 read data", {16'd0, rd_data}, 32'h1234);
    @(negedge clk);
    chk("R3 rd_valid single cycle", {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic t_image();
    int n, t0;
    t0 = txn;
    fire(1'b0, 1'b0, 1'b1, 2'd2, 4'd0, 16'h0);
    count_busy(n);
    chk("R5 busy cycles image", n, 32'd42);
    chk("R4 image transactions", txn - t0, 32'd6);
    for (int i = 0; i < 6; i++)
      chk("R4 image word", {16'd0, tmem[2][i]}, {16'd0, src_fn(3'(i))});
  endtask

  task automatic t_bad_addr();
    int t0;
    t0 = txn;
    fire(1'b1, 1'b0, 1'b0, 2'd3, 4'd1, 16'hDEAD);
    chk("R7 error cycle 1", {busy, error}, 32'b01);
    @(negedge clk);
    chk("R7 error cycle 2", {busy, error}, 32'b01);
    @(negedge clk);
    chk("R7 error ends", {30'd0, busy, error}, 32'b00);
    repeat (6) @(negedge clk);
    chk("R7 no transaction", txn - t0, 32'd0);
    chk("R7 target untouched", {16'd0, tmem[3][1]}, 32'd0);
  endtask

  task automatic t_multi();
    int t0;
    t0 = txn;
    fire(1'b1, 1'b1, 1'b0, 2'd0, 4'd7, 16'h5555);
    chk("R7 double pulse error", {30'd0, busy, error}, 32'b01);
    repeat (6) @(negedge clk);
    chk("R7 double pulse no transaction", txn - t0, 32'd0);
  endtask

  task automatic t_ignore();
    int n, t0;
    t0 = txn;
    fire(1'b0, 1'b1, 1'b0, 2'd0, 4'd0, 16'h0);
    fire(1'b1, 1'b0, 1'b0, 2'd0, 4'd2, 16'hBEEF);
    count_busy(n);
    repeat (6) @(negedge clk);
    chk("R8 busy pulse dropped", txn - t0, 32'd1);
    chk("R8 busy pulse no write", {16'd0, tmem[0][2]}, 32'd0);
    chk("R8 no error from dropped pulse", {31'd0, error}, 32'd0);
    t0 = txn;
    fire(1'b1, 1'b0, 1'b0, 2'd3, 4'd0, 16'h0);
    fire(1'b1, 1'b0, 1'b0, 2'd0, 4'd3, 16'hCAFE);
    repeat (8) @(negedge clk);
    chk("R8 pulse during error dropped", txn - t0, 32'd0);
    chk("R8 error pulse no write", {16'd0, tmem[0][3]}, 32'd0);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_cal();
    t_write_word();
    t_read_word();
    t_image();
    t_bad_addr();
    t_multi();
    t_ignore();
    chk("R6 handshake held until ack", hold_viol, 32'd0);
    report();
  end

endmodule